// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN message may enter the foreground receive buffer. It holds a bank of eight acceptance code bytes and eight mask bytes. A 2-bit organisation field groups that bank into two 32-bit filters, four 16-bit filters or eight 8-bit filters, or closes the filter so that nothing passes. Each filter compares its code bytes against the leading bytes of the received identifier. Bits whose mask bit is set are not compared.

When the receiver finishes a message it raises `eom` for one clock, with the identifier bytes on `msg_id`. The block evaluates every filter in that cycle. On the next clock edge it either pulses `accept` and records the index of the winning filter on `hit_idx`, or it drops the message. The input is a single-cycle strobe and there is no ready signal. Back-pressure comes from `fg_free`: a message that arrives while the foreground buffer cannot be loaded is dropped, and the recorded index is left as it was.

Configuration uses a byte-wide write port. Writes take effect only while initialization is both requested (`init_req`) and acknowledged (`init_ack`).

Top module: `can_id_filter`

## Requirements
- R1: After reset the organisation field is 00, all code and mask bytes are 0x00, `hit_idx` is 000 and `accept` is low. With these values, an identifier of all zeros hits filter 0, and an identifier that has any bit set in its first four bytes misses.
- R2: In organisation 00, filter 0 compares code/mask bytes 0..3 and filter 1 compares bytes 4..7 against identifier bytes 0..3. Identifier byte 0 is `msg_id[31:24]` and byte 3 is `msg_id[7:0]`.
- R3: In organisation 01, filter k (k = 0..3) compares bytes 2k and 2k+1 against identifier bytes 0 and 1.
- R4: In organisation 10, filter k (k = 0..7) compares byte k against identifier byte 0 only.
- R5: In organisation 11, no message is accepted and `hit_idx` does not change.
- R6: A mask bit of 1 makes the matching identifier bit a don't-care. A filter hits when every unmasked bit equals its code bit.
- R7: When several filters hit, `hit_idx` reports the lowest-numbered one, as a binary index from 000 (filter 0) to 111 (filter 7).
- R8: If no filter hits, `accept` stays low and `hit_idx` keeps its previous value.
- R9: `accept` is a one-cycle pulse. It is high in the cycle after an `eom` cycle in which some filter hit and `fg_free` was high. If `fg_free` was low, the message is dropped and `hit_idx` is unchanged.
- R10: `hit_idx` changes only in the cycle in which `accept` is high.
- R11: Writes change the bank only when `init_req` and `init_ack` are both high. Otherwise they are ignored. Address 0 is the control byte, with the organisation in bits [1:0]. Addresses 8..15 are code bytes 0..7 and addresses 16..23 are mask bytes 0..7.
- R12: Control-byte bits [6:4] are the read-only position of the hit index. Writing them has no effect on `hit_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Initialization requested |
| init_ack | input | 1 | Initialization acknowledged |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| eom | input | 1 | One-cycle end-of-message strobe |
| msg_id | input | 32 | Leading identifier bytes, byte 0 in [31:24] |
| fg_free | input | 1 | Foreground buffer can be loaded |
| accept | output | 1 | Load pulse for the foreground buffer |
| hit_idx | output | 3 | Index of the filter that accepted the held message |

## Verification
One fixed code/mask bank is run under each organisation. For each organisation the bench sends identifiers that hit exactly one filter, identifiers that hit none, and identifiers that hit several filters. Together these separate the byte grouping of each organisation, the lowest-index priority and the retention of the index on a miss. A partial mask in byte 4 and a full mask in byte 7 show that masked bits are ignored and that unmasked bits are compared. Directed cases cover the reset bank, writes made outside initialization, writes to the read-only index bits, the closed organisation and a busy foreground buffer.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int NBYTES   = 8;
  localparam int ID_BYTES = 4;
  localparam int IDX_W    = $clog2(NBYTES);
  localparam int ADDR_W   = 5;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] ADDR_CODE = 5'd8;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 5'd16;

  typedef enum logic [1:0] {
    ORG_W32 = 2'b00,
    ORG_W16 = 2'b01,
    ORG_W8  = 2'b10,
    ORG_OFF = 2'b11
  } org_e;
endpackage

// File: rtl/can_filt_cfg.sv
module can_filt_cfg
  import can_filt_pkg::*;
#(
  parameter int NB = NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output org_e              org_o,
  output logic [NB*8-1:0]   code_o,
  output logic [NB*8-1:0]   mask_o
);
  org_e              org_q;
  logic [NB*8-1:0]   code_q;
  logic [NB*8-1:0]   mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      org_q  <= ORG_W32;
      code_q <= '0;
      mask_q <= '0;
    end else if (open_i && we_i) begin
      // bits [6:4] of the control byte are read-only and never stored
      if (addr_i == ADDR_CTRL) org_q <= org_e'(wdata_i[1:0]);
      for (int i = 0; i < NB; i++) begin
        if (addr_i == ADDR_CODE + ADDR_W'(i)) code_q[8*i +: 8] <= wdata_i;
        if (addr_i == ADDR_MASK + ADDR_W'(i)) mask_q[8*i +: 8] <= wdata_i;
      end
    end
  end

  assign org_o  = org_q;
  assign code_o = code_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
  import can_filt_pkg::*;
#(
  parameter int NB  = NBYTES,
  parameter int IDB = ID_BYTES
) (
  input  org_e             org_i,
  input  logic [IDB*8-1:0] id_i,
  input  logic [NB*8-1:0]  code_i,
  input  logic [NB*8-1:0]  mask_i,
  output logic [NB-1:0]    hit_o
);
  localparam int N32 = NB / 4;
  localparam int N16 = NB / 2;

  logic [NB-1:0] m32, m16, m8;
  logic [NB-1:0] f32, f16;

  function automatic logic byte_ok(input logic [7:0] idb, input logic [7:0] c,
                                   input logic [7:0] m);
    return ((idb ^ c) & ~m) == 8'h00;
  endfunction

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam int P32 = i % 4;
    localparam int P16 = i % 2;
    assign m32[i] = byte_ok(id_i[IDB*8-1-8*P32 -: 8], code_i[8*i +: 8], mask_i[8*i +: 8]);
    assign m16[i] = byte_ok(id_i[IDB*8-1-8*P16 -: 8], code_i[8*i +: 8], mask_i[8*i +: 8]);
    assign m8[i]  = byte_ok(id_i[IDB*8-1 -: 8],       code_i[8*i +: 8], mask_i[8*i +: 8]);
  end

  for (genvar k = 0; k < NB; k++) begin : g_filt
    if (k < N32) begin : g_w32
      assign f32[k] = &m32[4*k +: 4];
    end else begin : g_w32_none
      assign f32[k] = 1'b0;
    end
    if (k < N16) begin : g_w16
      assign f16[k] = &m16[2*k +: 2];
    end else begin : g_w16_none
      assign f16[k] = 1'b0;
    end
  end

  always_comb begin
    unique case (org_i)
      ORG_W32: hit_o = f32;
      ORG_W16: hit_o = f16;
      ORG_W8:  hit_o = m8;
      default: hit_o = '0;
    endcase
  end
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio
  import can_filt_pkg::*;
#(
  parameter int NB = NBYTES,
  localparam int IW = $clog2(NB)
) (
  input  logic [NB-1:0] vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
    any_o = |vec_i;
  end
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_filt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_req,
  input  logic                  init_ack,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [7:0]            cfg_wdata,
  input  logic                  eom,
  input  logic [ID_BYTES*8-1:0] msg_id,
  input  logic                  fg_free,
  output logic                  accept,
  output logic [IDX_W-1:0]      hit_idx
);
  org_e                org_w;
  logic [NBYTES*8-1:0] code_w, mask_w;
  logic [NBYTES-1:0]   hit_vec;
  logic                any_hit;
  logic [IDX_W-1:0]    win_idx;
  logic                cfg_open;
  logic                accept_q;
  logic [IDX_W-1:0]    hit_q;

  assign cfg_open = init_req & init_ack;

  can_filt_cfg #(.NB(NBYTES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .open_i(cfg_open), .we_i(cfg_we),
    .addr_i(cfg_addr), .wdata_i(cfg_wdata),
    .org_o(org_w), .code_o(code_w), .mask_o(mask_w)
  );

  can_filt_match #(.NB(NBYTES), .IDB(ID_BYTES)) u_match (
    .org_i(org_w), .id_i(msg_id), .code_i(code_w), .mask_i(mask_w),
    .hit_o(hit_vec)
  );

  can_filt_prio #(.NB(NBYTES)) u_prio (
    .vec_i(hit_vec), .any_o(any_hit), .idx_o(win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept_q <= 1'b0;
      hit_q    <= '0;
    end else begin
      accept_q <= eom && fg_free && any_hit;
      if (eom && fg_free && any_hit) hit_q <= win_idx;
    end
  end

  assign accept  = accept_q;
  assign hit_idx = hit_q;
endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk
  import can_filt_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  eom,
  input logic                  fg_free,
  input logic                  accept,
  input logic [IDX_W-1:0]      hit_idx,
  input org_e                  org_w,
  input logic [NBYTES*8-1:0]   code_w,
  input logic [NBYTES*8-1:0]   mask_w,
  input logic                  cfg_open,
  input logic                  any_hit
);
  a_r9_accept_cause: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(eom && fg_free));

  a_r10_hit_held: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> $stable(hit_idx));

  a_r5_closed_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (eom && org_w == ORG_OFF) |=> !accept);

  a_r8_miss_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (eom && !any_hit) |=> !accept);

  a_r11_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(org_w) && $stable(code_w) && $stable(mask_w)));
endmodule

bind can_id_filter can_id_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eom(eom), .fg_free(fg_free), .accept(accept),
  .hit_idx(hit_idx), .org_w(org_w), .code_w(code_w), .mask_w(mask_w),
  .cfg_open(cfg_open), .any_hit(any_hit)
);

// File: tb/can_id_filter_test.sv
module can_id_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_req = 1'b0, init_ack = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        eom = 1'b0;
  logic [31:0] msg_id = '0;
  logic        fg_free = 1'b1;
  logic        accept;
  logic [2:0]  hit_idx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  can_id_filter uut (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .eom(eom), .msg_id(msg_id), .fg_free(fg_free),
    .accept(accept), .hit_idx(hit_idx)
  );

  // vector: {org[1:0], id[31:0], fg_free, exp_accept, exp_hit[2:0]}
  localparam int NV = 20;
  localparam logic [38:0] VEC [NV] = '{
    {2'b00, 32'h12345678, 1'b1, 1'b1, 3'd0},  // R2 filter 0 exact
    {2'b00, 32'hA5B1C2EE, 1'b1, 1'b1, 3'd1},  // R2/R6 filter 1, masked bits
    {2'b00, 32'h12345679, 1'b1, 1'b0, 3'd0},  // R8 miss keeps 1
    {2'b00, 32'hB5B1C2EE, 1'b1, 1'b0, 3'd0},  // R6 unmasked nibble differs
    {2'b01, 32'h1234ABCD, 1'b1, 1'b1, 3'd0},  // R3 filter 0
    {2'b01, 32'h56780000, 1'b1, 1'b1, 3'd1},  // R3 filter 1
    {2'b01, 32'hA3B10000, 1'b1, 1'b1, 3'd2},  // R3/R6 filter 2
    {2'b01, 32'hC2FF0000, 1'b1, 1'b1, 3'd3},  // R3/R6 filter 3 byte 7 masked
    {2'b01, 32'h99990000, 1'b1, 1'b0, 3'd0},  // R8 miss
    {2'b01, 32'h12340000, 1'b0, 1'b0, 3'd0},  // R9 buffer busy
    {2'b10, 32'h34000000, 1'b1, 1'b1, 3'd1},  // R4 filter 1
    {2'b10, 32'h56FFFFFF, 1'b1, 1'b1, 3'd2},  // R4 only byte 0 used
    {2'b10, 32'h78000000, 1'b1, 1'b1, 3'd3},  // R4
    {2'b10, 32'hA7000000, 1'b1, 1'b1, 3'd4},  // R4/R6
    {2'b10, 32'hB1000000, 1'b1, 1'b1, 3'd5},  // R4
    {2'b10, 32'hC2000000, 1'b1, 1'b1, 3'd6},  // R4
    {2'b10, 32'h00000000, 1'b1, 1'b1, 3'd7},  // R4/R6 only full-mask filter
    {2'b10, 32'h12000000, 1'b1, 1'b1, 3'd0},  // R7 filters 0 and 7 hit
    {2'b11, 32'h12345678, 1'b1, 1'b0, 3'd0},  // R5 closed
    {2'b11, 32'h00000000, 1'b1, 1'b0, 3'd0}   // R5 closed
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_org(input logic [1:0] o);
    init_req = 1'b1; init_ack = 1'b1;
    cfg_write(5'd0, {6'd0, o});
    init_req = 1'b0; init_ack = 1'b0;
  endtask

  // drive one strobe; returns at the negedge after the evaluating edge
  task automatic send(input logic [31:0] id, input logic free);
    @(negedge clk);
    eom = 1'b1; msg_id = id; fg_free = free;
    @(negedge clk);
    eom = 1'b0; fg_free = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [2:0] exp_hit;
    logic [1:0] cur_org;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset hit_idx", 32'(hit_idx), 0);
    check("R1 reset accept", 32'(accept), 0);

    send(32'h00000000, 1'b1);
    check("R1 zero id accepted", 32'(accept), 1);
    check("R1 zero id hit", 32'(hit_idx), 0);
    @(negedge clk);
    check("R9 accept one cycle", 32'(accept), 0);
    send(32'h01000000, 1'b1);
    check("R1 nonzero id rejected", 32'(accept), 0);

    // R11: writes outside initialization are ignored
    init_req = 1'b1; init_ack = 1'b0;
    cfg_write(5'd8, 8'hFF);
    cfg_write(5'd0, 8'h03);
    init_req = 1'b0; init_ack = 1'b1;
    cfg_write(5'd8, 8'hFF);
    init_ack = 1'b0;
    send(32'h00000000, 1'b1);
    check("R11 locked writes ignored", 32'(accept), 1);

    // load bank during initialization
    init_req = 1'b1; init_ack = 1'b1;
    cfg_write(5'd8,  8'h12); cfg_write(5'd9,  8'h34);
    cfg_write(5'd10, 8'h56); cfg_write(5'd11, 8'h78);
    cfg_write(5'd12, 8'hA0); cfg_write(5'd13, 8'hB1);
    cfg_write(5'd14, 8'hC2); cfg_write(5'd15, 8'hD3);
    cfg_write(5'd20, 8'h0F); cfg_write(5'd23, 8'hFF);
    init_req = 1'b0; init_ack = 1'b0;

    exp_hit = 3'd0;
    cur_org = 2'b00;
    for (int v = 0; v < NV; v++) begin
      logic [38:0] e;
      e = VEC[v];
      if (e[38:37] != cur_org) begin
        cur_org = e[38:37];
        set_org(cur_org);
      end
      send(e[36:5], e[4]);
      if (e[3]) exp_hit = e[2:0];
      check($sformatf("R2-R9 vector %0d accept", v), 32'(accept), 32'(e[3]));
      check($sformatf("R7 R8 R10 vector %0d hit", v), 32'(hit_idx), 32'(exp_hit));
    end

    // R12: writing the read-only index bits has no effect
    set_org(2'b10);
    send(32'hC2000000, 1'b1);
    check("R12 setup hit", 32'(hit_idx), 6);
    init_req = 1'b1; init_ack = 1'b1;
    cfg_write(5'd0, 8'h72);
    init_req = 1'b0; init_ack = 1'b0;
    check("R12 hit bits read-only", 32'(hit_idx), 6);

    // R5: closed organisation keeps the index
    set_org(2'b11);
    send(32'h12000000, 1'b1);
    check("R5 closed no accept", 32'(accept), 0);
    check("R5 closed hit kept", 32'(hit_idx), 6);

    // R9: busy buffer with a hit
    set_org(2'b10);
    send(32'h34000000, 1'b0);
    check("R9 busy no accept", 32'(accept), 0);
    check("R9 busy hit kept", 32'(hit_idx), 6);

    finish_run();
  end
endmodule